// File: doc/BRIEF.md
# Voice Envelope Generator with Stepped-Exponential Fall

This block produces the 8-bit amplitude envelope for one synthesizer voice. A gate input starts the note and ends it. While the gate is high, the level climbs to full scale, falls to a programmable hold level and stays there. When the gate drops, the level falls to zero. Three 4-bit rate inputs set the step period of the rise, the first fall and the final fall. A 4-bit hold value sets the level at which the first fall stops.

All timing comes from clock-enable pulses in a single clock domain. A rate prescaler produces a tick every `PRE_BASE*(rate+1)` cycles. The rise moves the level by one on every tick, which gives a straight line. During both falls, a second divider sits between the tick and the level counter. Its ratio depends on the current level and doubles as the level passes each of a fixed set of thresholds. The fall therefore approximates an exponential with straight segments, and the counter itself only ever moves by one.

Top module: `env_shaper`

## Requirements
- R1: After an active-low synchronous reset, `level` is 0 and `phase` is IDLE. The phase codes are IDLE=0, ATTACK=1, DECAY=2, SUSTAIN=3 and RELEASE=4.
- R2: A rising `gate` seen in IDLE sets `phase` to ATTACK one cycle later. In ATTACK the level rises by exactly one per prescaler tick, with no level-dependent shaping.
- R3: The prescaler period for a 4-bit rate r is `PRE_BASE*(r+1)` clock cycles, with `PRE_BASE` defaulting to 2. ATTACK uses `atk_rate`, DECAY uses `dcy_rate` and RELEASE uses `rel_rate`.
- R4: In ATTACK, a level of 255 moves the phase to DECAY on the next cycle, and the level does not wrap.
- R5: In DECAY and RELEASE, the number of cycles spent at level L is the prescaler period times a ratio. The ratio is 1 for L>93, 2 for 54<L<=93, 4 for 26<L<=54, 8 for 14<L<=26, 16 for 6<L<=14, and 30 for L<=6.
- R6: DECAY ends in SUSTAIN once the level is at or below the target formed by placing `sus_lvl` in both nibbles (0xA gives 0xAA).
- R7: A falling `gate` in ATTACK, DECAY or SUSTAIN sets the phase to RELEASE on the next cycle, and the level then falls with the R5 shaping at the `rel_rate` period.
- R8: RELEASE at level 0 moves the phase to IDLE. In IDLE the level is always 0.
- R9: A rising `gate` during RELEASE sets the phase back to ATTACK and keeps the current level, without returning to zero.
- R10: The level changes by at most one per cycle and saturates at 0 and 255. The sustain value 0xF makes the envelope hold at 255.
- R11: In SUSTAIN the level does not change while the gate stays high. In ATTACK it never falls, and in DECAY and RELEASE it never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gate | input | 1 | Note gate: high holds the note, low releases it |
| atk_rate | input | 4 | Rate code for the rise |
| dcy_rate | input | 4 | Rate code for the fall to the hold level |
| rel_rate | input | 4 | Rate code for the final fall |
| sus_lvl | input | 4 | Hold level, copied into both nibbles of the target |
| level | output | 8 | Envelope level |
| phase | output | 3 | Current phase code (R1 encoding) |

## Verification
A gate edge is registered and appears on `phase` at the first clock edge after the edge is sampled. The level never moves in the same cycle as a gate edge. After each level change, the next one is due exactly period×ratio cycles later, because both dividers restart on every step. The bench drives its inputs on the falling clock edge and compares `level` and `phase` against a behavioural model on every falling edge. It measures segment slopes by counting falling edges from the cycle a level first appears until it changes. Only levels reached by a step are measured, never the first level of a new phase, so every count is a whole period×ratio.

// File: rtl/env_pkg.sv
// Package: shared phase type and constants for the envelope generator.
// Assumes: 8-bit level, 4-bit rate and hold codes.
package env_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_ATTACK  = 3'd1,
        PH_DECAY   = 3'd2,
        PH_SUSTAIN = 3'd3,
        PH_RELEASE = 3'd4
    } env_phase_e;

    // Level thresholds of the shaped fall, highest first.
    localparam int unsigned NUM_EDGES = 5;
    localparam int unsigned BAND_EDGE [NUM_EDGES] = '{93, 54, 26, 14, 6};
    // Ratio applied below the lowest threshold.
    localparam int unsigned LAST_RATIO = 30;

    // Prescaler period in cycles for a rate code.
    function automatic int unsigned rate_period(int unsigned base, int unsigned code);
        return base * (code + 1);
    endfunction

endpackage

// File: rtl/env_prescaler.sv
// Module: rate prescaler.
// Emits a one-cycle tick every `period` cycles while `run` is high.
// Assumes: period >= 1. The count is held at zero while run is low.
module env_prescaler #(
    parameter int unsigned PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] period,
    output logic          tick
);
    logic [PW-1:0] cnt;

    // Tick on the last count of the period.
    assign tick = run && (cnt >= period - PW'(1));

    // Advance the count, or wrap it after a tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PW'(1);
        end
    end
endmodule

// File: rtl/env_expdiv.sv
// Module: level-indexed divider that sits between the tick and the level counter.
// With `shaped` low, every tick becomes a step. With it high, the ratio
// doubles at each threshold the level has passed, down to LAST_RATIO.
// Assumes: the count restarts on every step, so a new level gets a fresh ratio.
module env_expdiv #(
    parameter int unsigned LW = 8,
    parameter int unsigned EW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          shaped,
    input  logic          tick,
    input  logic [LW-1:0] level,
    output logic          step
);
    import env_pkg::*;

    logic [NUM_EDGES-1:0] below;
    logic [2:0]           band;
    logic [EW-1:0]        ratio;
    logic [EW-1:0]        cnt;

    // One comparator per threshold.
    for (genvar i = 0; i < NUM_EDGES; i++) begin : g_edge
        assign below[i] = (32'(level) <= BAND_EDGE[i]);
    end

    // Count the thresholds passed and map the band to a ratio.
    always_comb begin
        band = '0;
        for (int i = 0; i < NUM_EDGES; i++) begin
            band = band + 3'(below[i]);
        end
        if (!shaped)                      ratio = EW'(1);
        else if (32'(band) == NUM_EDGES)  ratio = EW'(LAST_RATIO);
        else                              ratio = EW'(1) << band;
    end

    // A step happens on the tick that completes the ratio.
    assign step = tick && (cnt >= ratio - EW'(1));

    // Count ticks between steps.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= step ? '0 : cnt + EW'(1);
        end
    end
endmodule

// File: rtl/env_core.sv
// Module: phase sequencer and saturating level counter.
// A gate edge takes priority over level movement in the cycle it is seen.
// Assumes: step is a single-cycle enable. The hold target is sus copied into both halves.
module env_core #(
    parameter int unsigned LW = 8,
    parameter int unsigned SW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gate,
    input  logic [SW-1:0]   sus,
    input  logic            step,
    output logic [LW-1:0]   level,
    output env_pkg::env_phase_e phase
);
    import env_pkg::*;

    localparam logic [LW-1:0] LVL_MAX = '1;

    logic          gate_q;
    logic          rise;
    logic          fall;
    logic [LW-1:0] target;

    assign rise   = gate && !gate_q;
    assign fall   = !gate && gate_q;
    assign target = LW'({sus, sus});

    // Sequence the phases and move the level one count per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            level  <= '0;
            gate_q <= 1'b0;
        end else begin
            gate_q <= gate;
            if (fall && (phase == PH_ATTACK || phase == PH_DECAY || phase == PH_SUSTAIN)) begin
                phase <= PH_RELEASE;
            end else if (rise && (phase == PH_IDLE || phase == PH_RELEASE)) begin
                phase <= PH_ATTACK;
            end else begin
                case (phase)
                    PH_ATTACK: begin
                        if (level == LVL_MAX)  phase <= PH_DECAY;
                        else if (step)         level <= level + LW'(1);
                    end
                    PH_DECAY: begin
                        if (level <= target)   phase <= PH_SUSTAIN;
                        else if (step)         level <= level - LW'(1);
                    end
                    PH_RELEASE: begin
                        if (level == '0)       phase <= PH_IDLE;
                        else if (step)         level <= level - LW'(1);
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/env_shaper.sv
// Module: top of the envelope generator.
// Selects the rate for the current phase and chains the prescaler, the shaping
// divider and the sequencer.
// Assumes: one clock domain. Every level step is a clock enable, never a clock.
module env_shaper #(
    parameter int unsigned PRE_BASE = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gate,
    input  logic [3:0] atk_rate,
    input  logic [3:0] dcy_rate,
    input  logic [3:0] rel_rate,
    input  logic [3:0] sus_lvl,
    output logic [7:0] level,
    output logic [2:0] phase
);
    import env_pkg::*;

    localparam int unsigned RW = 4;
    localparam int unsigned LW = 8;
    localparam int unsigned PW = $clog2(PRE_BASE * (2 ** RW) + 1);
    localparam int unsigned EW = $clog2(LAST_RATIO + 1);

    env_phase_e    ph;
    logic [RW-1:0] rate;
    logic [PW-1:0] period;
    logic          run;
    logic          shaped;
    logic          tick;
    logic          step;

    // Pick the rate code and the prescaler period for the current phase.
    always_comb begin
        case (ph)
            PH_ATTACK: rate = atk_rate;
            PH_DECAY:  rate = dcy_rate;
            default:   rate = rel_rate;
        endcase
        period = PW'(rate_period(PRE_BASE, 32'(rate)));
    end

    assign run    = (ph == PH_ATTACK) || (ph == PH_DECAY) || (ph == PH_RELEASE);
    assign shaped = (ph == PH_DECAY) || (ph == PH_RELEASE);
    assign phase  = ph;

    env_prescaler #(.PW(PW)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .period(period), .tick(tick)
    );

    env_expdiv #(.LW(LW), .EW(EW)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .shaped(shaped),
        .tick(tick), .level(level), .step(step)
    );

    env_core #(.LW(LW), .SW(RW)) u_core (
        .clk(clk), .rst_n(rst_n), .gate(gate), .sus(sus_lvl),
        .step(step), .level(level), .phase(ph)
    );
endmodule

// File: rtl/env_shaper_chk.sv
// Checker: temporal properties of the envelope generator, observed at its ports.
module env_shaper_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       gate,
    input logic [7:0] level,
    input logic [2:0] phase
);
    // R10
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == $past(level)) || (level == $past(level) + 8'd1) || (level == $past(level) - 8'd1));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd0) |-> (level == 8'd0));

    // R11
    attack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd1) |=> (level >= $past(level)));

    // R11
    fall_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd2 || phase == 3'd4) |=> (level <= $past(level)));

    // R11
    sustain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd3) |=> (phase != 3'd3 || level == $past(level)));

    // R4
    peak_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd1 && level == 8'd255 && gate) |=> (phase == 3'd2));

    // R7
    gate_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == 3'd1 || phase == 3'd2 || phase == 3'd3) && !gate && $past(gate)) |=> (phase == 3'd4));
endmodule

bind env_shaper env_shaper_chk u_chk (
    .clk(clk), .rst_n(rst_n), .gate(gate), .level(level), .phase(phase)
);

// File: tb/test_env_shaper.sv
module test_env_shaper;
    localparam time CLK_PERIOD = 10ns;
    localparam int  BASE = 2;
    localparam int  WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gate = 1'b0;
    logic [3:0] atk_rate = '0, dcy_rate = '0, rel_rate = '0, sus_lvl = '0;
    logic [7:0] level;
    logic [2:0] phase;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    env_shaper i_env_shaper (
        .clk(clk), .rst_n(rst_n), .gate(gate), .atk_rate(atk_rate),
        .dcy_rate(dcy_rate), .rel_rate(rel_rate), .sus_lvl(sus_lvl),
        .level(level), .phase(phase)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state.
    int m_ph = 0, m_lvl = 0, m_pre = 0, m_ex = 0, m_gq = 0;

    function automatic int ratio_of(int lv);
        if (lv > 93) return 1;
        if (lv > 54) return 2;
        if (lv > 26) return 4;
        if (lv > 14) return 8;
        if (lv > 6)  return 16;
        return 30;
    endfunction

    // Behavioural model, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_lvl = 0; m_pre = 0; m_ex = 0; m_gq = 0;
        end else begin
            automatic bit act = (m_ph == 1 || m_ph == 2 || m_ph == 4);
            automatic int r   = (m_ph == 1) ? atk_rate : (m_ph == 2) ? dcy_rate : rel_rate;
            automatic int per = BASE * (r + 1);
            automatic bit tk  = act && (m_pre >= per - 1);
            automatic int rat = (m_ph == 2 || m_ph == 4) ? ratio_of(m_lvl) : 1;
            automatic bit st  = tk && (m_ex >= rat - 1);
            automatic bit up  = gate && !m_gq;
            automatic bit dn  = !gate && m_gq;
            automatic int tgt = sus_lvl * 17;
            m_pre = !act ? 0 : (tk ? 0 : m_pre + 1);
            m_ex  = !act ? 0 : (tk ? (st ? 0 : m_ex + 1) : m_ex);
            if (dn && (m_ph == 1 || m_ph == 2 || m_ph == 3)) m_ph = 4;
            else if (up && (m_ph == 0 || m_ph == 4)) m_ph = 1;
            else if (m_ph == 1) begin
                if (m_lvl == 255) m_ph = 2; else if (st) m_lvl++;
            end else if (m_ph == 2) begin
                if (m_lvl <= tgt) m_ph = 3; else if (st) m_lvl--;
            end else if (m_ph == 4) begin
                if (m_lvl == 0) m_ph = 0; else if (st) m_lvl--;
            end
            m_gq = gate;
        end
    end

    task automatic chk(string req, int got, int exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Compare the design with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10 model level", int'(level), m_lvl);
            chk("R11 model phase", int'(phase), m_ph);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic wait_lvl(int v);
        while (int'(level) != v) @(negedge clk);
    endtask

    task automatic wait_ph(int v);
        while (int'(phase) != v) @(negedge clk);
    endtask

    // Cycles spent at level v, counted from the cycle it first appears.
    task automatic dwell(string req, int v, int exp);
        int n = 0;
        wait_lvl(v);
        while (int'(level) == v) begin
            @(negedge clk);
            n++;
        end
        chk(req, n, exp);
    endtask

    initial begin
        int held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset level", int'(level), 0);
        chk("R1 reset phase", int'(phase), 0);

        // Run A: fastest rates, hold target 0, covers every fall band.
        gate = 1'b1;
        @(negedge clk);
        chk("R2 enter attack", int'(phase), 1);
        dwell("R2 attack slope", 100, 2);
        wait_lvl(255);
        @(negedge clk);
        chk("R4 peak to decay", int'(phase), 2);
        dwell("R5 band ratio 1", 200, 2);
        dwell("R5 band ratio 2", 80, 4);
        dwell("R5 band ratio 4", 40, 8);
        dwell("R5 band ratio 8", 20, 16);
        dwell("R5 band ratio 16", 10, 32);
        dwell("R5 band ratio 30", 3, 60);
        wait_ph(3);
        chk("R6 zero target hold", int'(level), 0);
        gate = 1'b0;
        @(negedge clk);
        chk("R7 release from sustain", int'(phase), 4);
        @(negedge clk);
        chk("R8 release at zero ends", int'(phase), 0);
        repeat (40) @(negedge clk);
        chk("R10 floor holds", int'(level), 0);

        // Run B: slower rates, hold target 0xAA, retrigger during the fall.
        atk_rate = 4'd5; dcy_rate = 4'd3; rel_rate = 4'd1; sus_lvl = 4'hA;
        gate = 1'b1;
        dwell("R3 attack period rate 5", 50, 12);
        wait_ph(3);
        chk("R6 hold level 0xAA", int'(level), 170);
        repeat (200) @(negedge clk);
        chk("R11 sustain steady", int'(level), 170);
        chk("R11 sustain phase", int'(phase), 3);
        gate = 1'b0;
        @(negedge clk);
        chk("R7 gate drop", int'(phase), 4);
        dwell("R7 release ratio 1", 150, 4);
        dwell("R7 release ratio 2", 60, 8);
        dwell("R7 release ratio 4", 40, 16);
        wait_lvl(30);
        held = int'(level);
        gate = 1'b1;
        @(negedge clk);
        chk("R9 retrigger phase", int'(phase), 1);
        chk("R9 retrigger keeps level", int'(level), held);
        repeat (40) @(negedge clk);
        chk("R9 rises from held level", int'(level), held + 3);
        gate = 1'b0;
        dwell("R7 release ratio 30", 5, 120);
        wait_ph(0);
        chk("R8 idle at zero", int'(level), 0);

        // Run C: hold value 0xF keeps the level at full scale.
        atk_rate = 4'd0; sus_lvl = 4'hF;
        gate = 1'b1;
        wait_ph(3);
        repeat (20) @(negedge clk);
        chk("R10 ceiling holds", int'(level), 255);
        gate = 1'b0;
        wait_ph(0);
        chk("R8 final idle", int'(level), 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule